// File: doc/BRIEF.md
# Masked Hit-Pixel Timestamp Recorder

This block sits beside one row of binary pixels, 36 by default. Each pixel reports only hit or no hit. On every bunch-crossing strobe inside a train, the block captures the row's hit flags and removes any pixel disabled in a per-pixel noise mask. It then turns each surviving hit into a record that holds the pixel index and the timestamp of that crossing. The records go into a local register-array store, one per clock, lowest pixel index first.

While the train input is high, the block only records. Between trains, an external reader starts a readout and drains the stored records in write order through a ready/valid port. When the readout finishes, the store is emptied for the next train. The noise mask is loaded bit-serially, and only outside a train. A sticky flag reports any hit that was lost because the store was full.

Top module: `pixel_hit_recorder`

## Requirements
- R1: After reset, rd_valid_o, rd_busy_o and overflow_o are 0 and no pixel is masked.
- R2: When mask_shift_i is high and train_i is low, the mask shifts one place toward pixel 0 and mask_bit_i enters at pixel NUM_PIX-1. After NUM_PIX such shifts, the first bit entered controls pixel 0. A mask bit of 1 disables its pixel.
- R3: A hit on a masked pixel is never written to the store.
- R4: A record holds a 6-bit pixel index (0 to NUM_PIX-1) and a 13-bit timestamp. The timestamp is 0 at the first crossing of a train and rises by 1 at each later crossing of that train. The counter clears whenever train_i is low.
- R5: When several unmasked pixels hit in one crossing, their records are written one per clock in ascending pixel index.
- R6: mask_shift_i has no effect while train_i is high.
- R7: rd_start_i is ignored while train_i is high, so no readout begins.
- R8: An accepted readout raises rd_busy_o and presents the records in write order. A record is consumed on a clock where rd_valid_o and rd_ready_i are both high. While rd_ready_i is low, rd_valid_o and the record stay unchanged.
- R9: Once DEPTH records are stored, further hits are dropped and overflow_o goes high. overflow_o stays high until the next accepted readout start clears it.
- R10: When every record has been consumed, rd_busy_o falls and the store is empty. A readout started right after that presents no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| train_i | input | 1 | High during a bunch train (record phase) |
| bx_i | input | 1 | One-cycle bunch-crossing strobe |
| hits_i | input | NUM_PIX | Hit flag per pixel, sampled on bx_i |
| mask_shift_i | input | 1 | Shift enable for the serial mask load |
| mask_bit_i | input | 1 | Serial mask data bit (1 = pixel disabled) |
| rd_start_i | input | 1 | Request to begin a readout |
| rd_ready_i | input | 1 | Reader accepts the presented record |
| rd_valid_o | output | 1 | A record is presented |
| rd_pix_o | output | 6 | Pixel index of the presented record |
| rd_ts_o | output | 13 | Timestamp of the presented record |
| rd_busy_o | output | 1 | Readout in progress |
| overflow_o | output | 1 | Sticky flag: a hit was lost because the store was full |

## Verification
The embedded assertions check these properties on every cycle:
- no write reaches the store when it is full or targets a masked pixel;
- pixel indices are always in range and rise within a crossing;
- the mask stays frozen during a train;
- no readout begins during a train;
- a stalled record holds still;
- the overflow flag is sticky.

Only the bench scenarios can show the end-to-end results:
- the actual contents and order of the drained records;
- the per-train timestamp restart;
- the serial mask bit order;
- that exactly DEPTH records survive a flood;
- that a second readout returns nothing.

// File: rtl/hitrec_pkg.sv
package hitrec_pkg;
  parameter int PIX_W = 6;
  parameter int TS_W  = 13;

  typedef struct packed {
    logic [PIX_W-1:0] pix;
    logic [TS_W-1:0]  ts;
  } hit_rec_t;
endpackage

// File: rtl/hitrec_prio.sv
module hitrec_prio
  import hitrec_pkg::*;
#(
  parameter int NUM_PIX = 36
) (
  input  logic [NUM_PIX-1:0] req_i,
  output logic [PIX_W-1:0]   idx_o,
  output logic               valid_o
);
  // scan high to low so the lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_PIX - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = PIX_W'(i);
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/hitrec_mask.sv
module hitrec_mask #(
  parameter int NUM_PIX = 36
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_i,
  input  logic               bit_i,
  output logic [NUM_PIX-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_o <= '0;
    else if (shift_i) mask_o <= {bit_i, mask_o[NUM_PIX-1:1]};
  end
endmodule

// File: rtl/hitrec_store.sv
module hitrec_store
  import hitrec_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  hit_rec_t wr_rec_i,
  input  logic     clr_i,
  input  logic [AW-1:0] rd_idx_i,
  output hit_rec_t rd_rec_o,
  output logic [CW-1:0] count_o,
  output logic     full_o
);
  hit_rec_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i) mem[count_o[AW-1:0]] <= wr_rec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_o <= '0;
    else if (clr_i) count_o <= '0;
    else if (wr_i)  count_o <= count_o + 1'b1;
  end

  assign full_o   = (count_o == CW'(DEPTH));
  assign rd_rec_o = mem[rd_idx_i];

  p_no_write_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (count_o < CW'(DEPTH)));
  p_clear_empties_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0));
endmodule

// File: rtl/pixel_hit_recorder.sv
module pixel_hit_recorder
  import hitrec_pkg::*;
#(
  parameter int NUM_PIX = 36,
  parameter int DEPTH   = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               train_i,
  input  logic               bx_i,
  input  logic [NUM_PIX-1:0] hits_i,
  input  logic               mask_shift_i,
  input  logic               mask_bit_i,
  input  logic               rd_start_i,
  input  logic               rd_ready_i,
  output logic               rd_valid_o,
  output logic [PIX_W-1:0]   rd_pix_o,
  output logic [TS_W-1:0]    rd_ts_o,
  output logic               rd_busy_o,
  output logic               overflow_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [NUM_PIX-1:0] mask, pend_q;
  logic [TS_W-1:0]    ts_q, stamp_q;
  logic [PIX_W-1:0]   scan_idx;
  logic               scan_vld, scan_busy, bx_load, mask_en;
  logic               rd_mode_q, ovf_q, start_acc, rd_empty, full, wr_en, clr;
  logic [CW-1:0]      rd_ptr_q, count;
  hit_rec_t           wr_rec, rd_rec;

  assign scan_busy = |pend_q;
  assign bx_load   = bx_i && train_i && !rd_mode_q;
  assign mask_en   = mask_shift_i && !train_i && !scan_busy;
  assign start_acc = rd_start_i && !train_i && !rd_mode_q && !scan_busy;

  hitrec_mask #(.NUM_PIX(NUM_PIX)) u_mask (
    .clk_i, .rst_ni, .shift_i(mask_en), .bit_i(mask_bit_i), .mask_o(mask)
  );

  hitrec_prio #(.NUM_PIX(NUM_PIX)) u_prio (
    .req_i(pend_q), .idx_o(scan_idx), .valid_o(scan_vld)
  );

  assign wr_en      = scan_vld && !full;
  assign wr_rec.pix = scan_idx;
  assign wr_rec.ts  = stamp_q;
  assign rd_empty   = (rd_ptr_q == count);
  assign clr        = rd_mode_q && rd_empty;

  hitrec_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .wr_i(wr_en), .wr_rec_i(wr_rec), .clr_i(clr),
    .rd_idx_i(rd_ptr_q[AW-1:0]), .rd_rec_o(rd_rec), .count_o(count), .full_o(full)
  );

  // crossing counter: holds 0 outside a train
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ts_q <= '0;
    else if (!train_i) ts_q <= '0;
    else if (bx_load)  ts_q <= ts_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      stamp_q <= '0;
    end else if (bx_load) begin
      pend_q  <= hits_i & ~mask;
      stamp_q <= ts_q;
    end else if (scan_vld) begin
      pend_q  <= pend_q & ~(NUM_PIX'(1) << scan_idx);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ovf_q <= 1'b0;
    else if (start_acc)         ovf_q <= 1'b0;
    else if (scan_vld && full)  ovf_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_mode_q <= 1'b0;
      rd_ptr_q  <= '0;
    end else if (start_acc) begin
      rd_mode_q <= 1'b1;
      rd_ptr_q  <= '0;
    end else if (rd_mode_q) begin
      if (rd_empty) begin
        rd_mode_q <= 1'b0;
        rd_ptr_q  <= '0;
      end else if (rd_ready_i) begin
        rd_ptr_q  <= rd_ptr_q + 1'b1;
      end
    end
  end

  assign rd_valid_o = rd_mode_q && !rd_empty;
  assign rd_pix_o   = rd_rec.pix;
  assign rd_ts_o    = rd_rec.ts;
  assign rd_busy_o  = rd_mode_q;
  assign overflow_o = ovf_q;

  p_masked_never_written_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !mask[scan_idx]);
  p_pix_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (scan_idx < PIX_W'(NUM_PIX)));
  p_ascending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && $past(wr_en) && !$past(bx_load)) |-> (scan_idx > $past(scan_idx)));
  p_mask_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_i |=> $stable(mask));
  p_no_start_in_train_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_busy_o) |-> !$past(train_i));
  p_stall_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_pix_o) && $stable(rd_ts_o)));
  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !rd_start_i) |=> overflow_o);
endmodule

// File: tb/sim_pixel_hit_recorder.sv
`timescale 1ns/1ps
module sim_pixel_hit_recorder;
  localparam int NP = 36;
  localparam int DP = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic train_i = 0, bx_i = 0, mask_shift_i = 0, mask_bit_i = 0, rd_start_i = 0, rd_ready_i = 0;
  logic [NP-1:0] hits_i = '0;
  logic rd_valid_o, rd_busy_o, overflow_o;
  logic [5:0]  rd_pix_o;
  logic [12:0] rd_ts_o;

  int checks = 0, errors = 0;
  logic [18:0] exp_q [$];
  logic [NP-1:0] mask_m = '0;
  int cnt_m = 0;
  int ts_m = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pixel_hit_recorder #(.NUM_PIX(NP), .DEPTH(DP)) u0 (
    .clk_i(clk), .rst_ni, .train_i, .bx_i, .hits_i, .mask_shift_i, .mask_bit_i,
    .rd_start_i, .rd_ready_i, .rd_valid_o, .rd_pix_o, .rd_ts_o, .rd_busy_o, .overflow_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load_mask(input logic [NP-1:0] m);
    for (int i = 0; i < NP; i++) begin
      mask_shift_i = 1; mask_bit_i = m[i];
      tick();
    end
    mask_shift_i = 0; mask_bit_i = 0;
    if (!train_i) mask_m = m;
  endtask

  // driver: push expected records, ascending index (R5), masked dropped (R3)
  task automatic crossing(input logic [NP-1:0] h);
    for (int i = 0; i < NP; i++) begin
      if (h[i] && !mask_m[i]) begin
        if (cnt_m < DP) begin
          exp_q.push_back({6'(i), 13'(ts_m)});
          cnt_m++;
        end
      end
    end
    ts_m++;
    bx_i = 1; hits_i = h;
    tick();
    bx_i = 0; hits_i = '0;
    repeat (40) tick();
  endtask

  task automatic start_train();
    train_i = 1; ts_m = 0;  // R4 counter restarts
    tick();
  endtask

  task automatic end_train();
    train_i = 0;
    repeat (2) tick();
  endtask

  task automatic readout(input bit stall);
    int cyc = 0;
    rd_start_i = 1;
    tick();
    rd_start_i = 0;
    chk(rd_busy_o == 1, "R8 busy after start", rd_busy_o, 1);
    chk(overflow_o == 0, "R9 overflow cleared at start", overflow_o, 0);
    while (rd_busy_o && cyc < 5000) begin
      rd_ready_i = stall ? ((cyc % 3) != 0) : 1'b1;
      cyc++;
      tick();
    end
    rd_ready_i = 0;
    chk(exp_q.size() == 0, "R8 all records drained", exp_q.size(), 0);
    cnt_m = 0;
  endtask

  // monitor: pop and compare on each handshake; watch stalls (R8)
  logic       prev_stall = 0;
  logic [18:0] prev_rec  = '0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_stall) begin
        chk(rd_valid_o && {rd_pix_o, rd_ts_o} == prev_rec, "R8 stall holds record",
            {rd_pix_o, rd_ts_o}, prev_rec);
      end
      if (rd_valid_o && rd_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected record", {rd_pix_o, rd_ts_o}, 0);
        end else begin
          logic [18:0] e;
          e = exp_q.pop_front();
          chk({rd_pix_o, rd_ts_o} == e, "R4 record pix/ts", {rd_pix_o, rd_ts_o}, e);
        end
      end
      prev_stall = rd_valid_o && !rd_ready_i;
      prev_rec   = {rd_pix_o, rd_ts_o};
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] m;
    repeat (3) tick();
    rst_ni = 1;
    tick();
    // R1 reset state
    chk(rd_valid_o == 0, "R1 rd_valid", rd_valid_o, 0);
    chk(rd_busy_o == 0, "R1 rd_busy", rd_busy_o, 0);
    chk(overflow_o == 0, "R1 overflow", overflow_o, 0);

    // R1: empty mask lets every pixel through
    start_train();
    crossing({NP{1'b1}});
    end_train();
    readout(0);

    // R2: serial mask load, pixels 3, 17, 35 disabled
    m = '0; m[3] = 1; m[17] = 1; m[35] = 1;
    load_mask(m);

    start_train();
    // R6: shifting during a train has no effect
    load_mask({NP{1'b1}});
    // R7: readout request during a train is ignored
    rd_start_i = 1; tick(); rd_start_i = 0; tick();
    chk(rd_busy_o == 0, "R7 busy stays low", rd_busy_o, 0);
    chk(rd_valid_o == 0, "R7 valid stays low", rd_valid_o, 0);
    // R3 R5 patterns
    crossing(36'h0_0000_0029);           // pixels 0,3,5
    crossing({NP{1'b1}});
    crossing(36'hC_0002_0000);           // pixels 17,34,35
    crossing('0);
    crossing(36'h8_0000_0001);           // pixels 0,35
    end_train();
    chk(overflow_o == 0, "R9 no overflow under depth", overflow_o, 0);
    readout(1);                          // R8 with stalls

    // R10: immediate second readout returns nothing
    rd_start_i = 1; tick(); rd_start_i = 0;
    chk(rd_valid_o == 0, "R10 empty after readout", rd_valid_o, 0);
    while (rd_busy_o) tick();
    chk(exp_q.size() == 0, "R10 no stray records", exp_q.size(), 0);

    // R9: flood the store, timestamps restart (R4)
    load_mask('0);
    start_train();
    crossing({NP{1'b1}});
    crossing({NP{1'b1}});
    end_train();
    chk(overflow_o == 1, "R9 overflow set", overflow_o, 1);
    repeat (5) tick();
    chk(overflow_o == 1, "R9 overflow sticky", overflow_o, 1);
    chk(exp_q.size() == DP, "R9 model depth", exp_q.size(), DP);
    readout(0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule